// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block turns a word of already-synchronized input pins into interrupt requests. Each pin carries a 4-bit sense code that selects what counts as an event: a rising edge, a falling edge, both edges, a high level or a low level. A detected event sets a per-pin raw pending bit, but only while that pin's detection enable bit is on. Software acknowledges events by writing ones to a clear register.

A separate mask word decides which pending bits reach the interrupt outputs. Software changes it only through two write strobes: one register turns mask bits on and the other turns them off. The masked status word is split into halves. Each half drives one interrupt request line, so two handlers can service different pin groups.

All registers sit on a simple 32-bit register bus. Writes take effect at the clock edge, and reads return data combinationally from the read address.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset, every sense field, the detection enable word, the unmask word and the raw pending word read as zero, and both interrupt outputs are low.
- R2: Offset 0x14 is a read/write detection enable word. While bit n is 0, pin n sets no new pending bit, and a bit that is already pending stays set.
- R3: Writing to offset 0x18 unmasks every pin whose data bit is 1. Writing to offset 0x1C masks every pin whose data bit is 1. Zero data bits leave the mask unchanged. Offset 0x18 reads back the unmask word, where 1 means unmasked.
- R4: Sense codes are read/write in four registers at 0x40, 0x44, 0x48 and 0x4C. Pin n uses register n/8, bits [4*(n%8)+3 : 4*(n%8)].
- R5: Code 0x8 detects rising edges, code 0x9 detects falling edges and code 0xC detects both. Each qualifying edge sets the pending bit once, and a steady pin does not set it again after a clear.
- R6: Code 0xA (high) and code 0xB (low) set the pending bit on every clock in which the level is active, so a clear written while the level is still active leaves the bit set.
- R7: Any sense code other than 0x8 to 0xC disables detection for that pin.
- R8: Writing ones to offset 0x28 clears those pending bits, and zero bits leave the others alone. Offset 0x28 reads as zero.
- R9: When a clear and a new event for the same pin fall in the same clock, the pending bit stays set.
- R10: Offset 0x20 reads the raw pending word. Offset 0x24 reads the raw pending word ANDed with the unmask word.
- R11: The first interrupt output is high exactly when bits 15..0 of the masked status are non-zero. The second is high exactly when bits 31..16 are non-zero.
- R12: Pin events are sampled at the clock edge. An edge is detected against the pin value of the previous clock, and the pending bit first reads as set after the edge at which the event is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data for rd_addr |
| irq_o | output | 2 | Interrupt requests: bit 0 for pins 0..15, bit 1 for pins 16..31 |

## Verification
The bench builds the block with its defaults: 32 pins, two interrupt lines and unregistered interrupt outputs. These values put real pins on both sides of each sense-register boundary (pin 9 in the second register, pin 20 in the third, pin 31 in the top field of the last). They also put pins on both sides of the split between the two interrupt lines. The registered-output variant and other pin counts are reachable only through the elaboration checks and the bound properties, not through directed stimulus.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

   localparam int FIELD_W = 4;

   // register byte offsets; software depends on these positions
   localparam int OFS_DET_EN  = 'h14;
   localparam int OFS_UNMASK  = 'h18;
   localparam int OFS_MASK    = 'h1C;
   localparam int OFS_RAW     = 'h20;
   localparam int OFS_STATUS  = 'h24;
   localparam int OFS_CLEAR   = 'h28;
   localparam int OFS_SENSE0  = 'h40;

   typedef enum logic [FIELD_W-1:0] {
      SNS_RISE = 4'h8,
      SNS_FALL = 4'h9,
      SNS_HIGH = 4'hA,
      SNS_LOW  = 4'hB,
      SNS_BOTH = 4'hC
   } sense_code_e;

endpackage

// File: rtl/pin_event_cell.sv
module pin_event_cell
   import pin_event_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_i,
   input  logic [FIELD_W-1:0] code_i,
   input  logic               det_en_i,
   input  logic               clr_i,
   output logic               pend_o
);

   logic prev_q;
   logic pend_q;
   logic hit;

   always_comb begin
      case (code_i)
         SNS_RISE: hit = pin_i & ~prev_q;
         SNS_FALL: hit = ~pin_i & prev_q;
         SNS_HIGH: hit = pin_i;
         SNS_LOW:  hit = ~pin_i;
         SNS_BOTH: hit = pin_i ^ prev_q;
         default:  hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_i;
         // a fresh event overrides a simultaneous clear
         if (hit && det_en_i)
            pend_q <= 1'b1;
         else if (clr_i)
            pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/pin_event_regs.sv
module pin_event_regs
   import pin_event_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int AW    = 8,
   parameter int DW    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic [AW-1:0]            rd_addr,
   output logic [DW-1:0]            rd_data,
   input  logic [NPINS-1:0]         raw_i,
   output logic [NPINS-1:0]         det_en_o,
   output logic [NPINS-1:0]         unmask_o,
   output logic [NPINS-1:0]         clr_o,
   output logic [NPINS*FIELD_W-1:0] sense_o
);

   localparam int NSREG = (NPINS * FIELD_W) / DW;

   logic [NPINS-1:0]            det_en_q;
   logic [NPINS-1:0]            unmask_q;
   logic [NSREG-1:0][DW-1:0]    sense_q;
   logic                        wr_det, wr_set, wr_clr, wr_ack;
   logic [NPINS-1:0]            wr_bits;

   assign wr_bits = wr_data[NPINS-1:0];
   assign wr_det  = wr_en && (wr_addr == AW'(OFS_DET_EN));
   assign wr_set  = wr_en && (wr_addr == AW'(OFS_UNMASK));
   assign wr_clr  = wr_en && (wr_addr == AW'(OFS_MASK));
   assign wr_ack  = wr_en && (wr_addr == AW'(OFS_CLEAR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det_en_q <= '0;
         unmask_q <= '0;
      end else begin
         if (wr_det) det_en_q <= wr_bits;
         if (wr_set) unmask_q <= unmask_q | wr_bits;
         else if (wr_clr) unmask_q <= unmask_q & ~wr_bits;
      end
   end

   for (genvar k = 0; k < NSREG; k++) begin : g_sense
      logic wr_here;
      assign wr_here = wr_en && (wr_addr == AW'(OFS_SENSE0 + 4 * k));
      always_ff @(posedge clk) begin
         if (!rst_n)
            sense_q[k] <= '0;
         else if (wr_here)
            sense_q[k] <= wr_data;
      end
   end

   assign clr_o    = wr_ack ? wr_bits : '0;
   assign det_en_o = det_en_q;
   assign unmask_o = unmask_q;
   assign sense_o  = sense_q;

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(OFS_DET_EN)) rd_data[NPINS-1:0] = det_en_q;
      if (rd_addr == AW'(OFS_UNMASK)) rd_data[NPINS-1:0] = unmask_q;
      if (rd_addr == AW'(OFS_RAW))    rd_data[NPINS-1:0] = raw_i;
      if (rd_addr == AW'(OFS_STATUS)) rd_data[NPINS-1:0] = raw_i & unmask_q;
      for (int k = 0; k < NSREG; k++) begin
         if (rd_addr == AW'(OFS_SENSE0 + 4 * k)) rd_data = sense_q[k];
      end
   end

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
   parameter int NPINS   = 32,
   parameter int NIRQ    = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] status_i,
   output logic [NIRQ-1:0]  irq_o
);

   localparam int GRP = NPINS / NIRQ;

   for (genvar g = 0; g < NIRQ; g++) begin : g_line
      logic any;
      assign any = |status_i[g*GRP +: GRP];
      if (IRQ_REG) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= any;
         end
         assign irq_o[g] = q;
      end else begin : g_comb
         assign irq_o[g] = any;
      end
   end

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
   import pin_event_pkg::*;
#(
   parameter int NPINS   = 32,
   parameter int NIRQ    = 2,
   parameter int AW      = 8,
   parameter int DW      = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_i,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data,
   output logic [NIRQ-1:0]  irq_o
);

   if (NPINS > DW) begin : g_bad_width
      $error("pin count exceeds bus width");
   end
   if ((NPINS * FIELD_W) % DW != 0) begin : g_bad_pack
      $error("sense fields must fill whole registers");
   end
   if (NPINS % NIRQ != 0) begin : g_bad_split
      $error("pins must split evenly across interrupt lines");
   end

   logic [NPINS-1:0]         raw_pend;
   logic [NPINS-1:0]         det_en_q;
   logic [NPINS-1:0]         unmask_q;
   logic [NPINS-1:0]         clr_vec;
   logic [NPINS*FIELD_W-1:0] sense_vec;

   pin_event_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .raw_i    (raw_pend),
      .det_en_o (det_en_q),
      .unmask_o (unmask_q),
      .clr_o    (clr_vec),
      .sense_o  (sense_vec)
   );

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      pin_event_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_i    (pin_i[n]),
         .code_i   (sense_vec[n*FIELD_W +: FIELD_W]),
         .det_en_i (det_en_q[n]),
         .clr_i    (clr_vec[n]),
         .pend_o   (raw_pend[n])
      );
   end

   pin_event_irq #(.NPINS(NPINS), .NIRQ(NIRQ), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (raw_pend & unmask_q),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk
   import pin_event_pkg::*;
#(
   parameter int NPINS   = 32,
   parameter int NIRQ    = 2,
   parameter int AW      = 8,
   parameter int DW      = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [AW-1:0]    wr_addr,
   input logic [DW-1:0]    wr_data,
   input logic [NPINS-1:0] raw,
   input logic [NPINS-1:0] unmask,
   input logic [NPINS-1:0] det_en,
   input logic [NIRQ-1:0]  irq
);

   localparam int GRP = NPINS / NIRQ;

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (raw == '0 && unmask == '0 && det_en == '0 && irq == '0));

   // R3
   unmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(OFS_UNMASK)) |=>
         ((unmask & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0])
          && (unmask & ~$past(wr_data[NPINS-1:0])) == ($past(unmask) & ~$past(wr_data[NPINS-1:0]))));

   // R3
   unmask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(OFS_MASK)) |=>
         ((unmask & $past(wr_data[NPINS-1:0])) == '0
          && (unmask & ~$past(wr_data[NPINS-1:0])) == ($past(unmask) & ~$past(wr_data[NPINS-1:0]))));

   // R2
   no_capture_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) or !$rose(rst_n) |=> ((raw & ~$past(raw) & ~$past(det_en)) == '0));

   for (genvar g = 0; g < NIRQ; g++) begin : g_line_chk
      if (IRQ_REG) begin : g_r
         // R11
         irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(raw[g*GRP +: GRP] & unmask[g*GRP +: GRP])) |=> irq[g]);
      end else begin : g_c
         // R11
         irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] == (|(raw[g*GRP +: GRP] & unmask[g*GRP +: GRP])));
      end
   end

endmodule

bind pin_event_ctrl pin_event_chk #(
   .NPINS(NPINS), .NIRQ(NIRQ), .AW(AW), .DW(DW), .IRQ_REG(IRQ_REG)
) u_pin_event_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .raw     (raw_pend),
   .unmask  (unmask_q),
   .det_en  (det_en_q),
   .irq     (irq_o)
);

// File: tb/test_pin_event_ctrl.sv
`timescale 1ns/1ps
module test_pin_event_ctrl;

   localparam logic [31:0] P = 32'h0010_0002; // idle pins: pin1 and pin20 high

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_i = P;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  irq_o;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   pin_event_ctrl i_pin_event_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic step_pins(input logic [31:0] v);
      @(negedge clk);
      pin_i = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 irq", {30'd0, irq_o}, 32'd0);
      rd_chk("R1 raw", 8'h20, 0);
      rd_chk("R1 unmask", 8'h18, 0);
      rd_chk("R1 det_en", 8'h14, 0);
      for (int k = 0; k < 4; k++) rd_chk("R1 sense", 8'(8'h40 + 4 * k), 0);
   endtask

   task automatic t_regs;
      bus_write(8'h40, 32'h0000_0598);
      bus_write(8'h44, 32'h0000_00A0);
      bus_write(8'h48, 32'h000B_0000);
      bus_write(8'h4C, 32'hC000_0000);
      bus_write(8'h14, 32'hFFFF_FFFF);
      rd_chk("R4 sense0", 8'h40, 32'h0000_0598);
      rd_chk("R4 sense1", 8'h44, 32'h0000_00A0);
      rd_chk("R4 sense2", 8'h48, 32'h000B_0000);
      rd_chk("R4 sense3", 8'h4C, 32'hC000_0000);
      rd_chk("R2 det_en rw", 8'h14, 32'hFFFF_FFFF);
      rd_chk("R10 raw idle", 8'h20, 0);
   endtask

   task automatic t_mask;
      bus_write(8'h18, 32'h0000_00F0);
      rd_chk("R3 set", 8'h18, 32'h0000_00F0);
      bus_write(8'h18, 32'h0000_0003);
      rd_chk("R3 set keeps", 8'h18, 32'h0000_00F3);
      bus_write(8'h1C, 32'h0000_0010);
      rd_chk("R3 clr", 8'h18, 32'h0000_00E3);
      bus_write(8'h1C, 32'hFFFF_FFFF);
      rd_chk("R3 clr all", 8'h18, 0);
   endtask

   task automatic t_edge;
      @(negedge clk);
      pin_i = P | 32'h1;
      rd_chk("R12 not yet", 8'h20, 0);
      @(negedge clk);
      rd_chk("R12 R5 rise", 8'h20, 32'h1);
      bus_write(8'h28, 32'h1);
      rd_chk("R5 rise once", 8'h20, 0);
      step_pins(P | 32'h1);
      rd_chk("R5 steady", 8'h20, 0);
      step_pins(P);
      rd_chk("R5 rise ignores fall", 8'h20, 0);
      step_pins(P & ~32'h2);
      rd_chk("R5 fall", 8'h20, 32'h2);
      bus_write(8'h28, 32'hFFFF_FFFF);
      step_pins(P);
      rd_chk("R5 fall ignores rise", 8'h20, 0);
      step_pins(P | 32'h8000_0000);
      rd_chk("R5 both rise", 8'h20, 32'h8000_0000);
      bus_write(8'h28, 32'hFFFF_FFFF);
      step_pins(P);
      rd_chk("R5 both fall", 8'h20, 32'h8000_0000);
      bus_write(8'h28, 32'hFFFF_FFFF);
   endtask

   task automatic t_level;
      step_pins(P | 32'h200);
      rd_chk("R6 high", 8'h20, 32'h200);
      bus_write(8'h28, 32'h200);
      rd_chk("R6 high re-sets", 8'h20, 32'h200);
      step_pins(P);
      bus_write(8'h28, 32'h200);
      rd_chk("R6 high gone", 8'h20, 0);
      step_pins(P & ~32'h0010_0000);
      rd_chk("R6 low", 8'h20, 32'h0010_0000);
      bus_write(8'h28, 32'h0010_0000);
      rd_chk("R6 low re-sets", 8'h20, 32'h0010_0000);
      step_pins(P);
      bus_write(8'h28, 32'h0010_0000);
      rd_chk("R6 low gone", 8'h20, 0);
   endtask

   task automatic t_invalid;
      step_pins(P | 32'h4);
      step_pins(P);
      rd_chk("R7 code 5", 8'h20, 0);
   endtask

   task automatic t_detect;
      step_pins(P | 32'h8000_0000);
      bus_write(8'h14, 32'h7FFF_FFFE);
      step_pins(P | 32'h8000_0001);
      rd_chk("R2 no capture", 8'h20, 32'h8000_0000);
      step_pins(P);
      rd_chk("R2 held", 8'h20, 32'h8000_0000);
      bus_write(8'h28, 32'hFFFF_FFFF);
      bus_write(8'h14, 32'hFFFF_FFFF);
      rd_chk("R2 cleared", 8'h20, 0);
   endtask

   task automatic t_race;
      @(negedge clk);
      pin_i = P | 32'h1;
      wr_en = 1'b1; wr_addr = 8'h28; wr_data = 32'h1;
      @(negedge clk);
      wr_en = 1'b0;
      rd_chk("R9 event wins", 8'h20, 32'h1);
      bus_write(8'h28, 32'h1);
      step_pins(P);
      rd_chk("R9 cleared after", 8'h20, 0);
   endtask

   task automatic t_clear;
      step_pins((P | 32'h1) & ~32'h2);
      rd_chk("R8 two pending", 8'h20, 32'h3);
      bus_write(8'h28, 32'h1);
      rd_chk("R8 partial", 8'h20, 32'h2);
      rd_chk("R8 reads zero", 8'h28, 0);
      bus_write(8'h28, 32'hFFFF_FFFF);
      step_pins(P);
      rd_chk("R8 all clear", 8'h20, 0);
   endtask

   task automatic t_status_irq;
      step_pins(P | 32'h200);
      step_pins(P);
      step_pins(P & ~32'h0010_0000);
      step_pins(P);
      rd_chk("R10 raw", 8'h20, 32'h0010_0200);
      rd_chk("R10 masked", 8'h24, 0);
      chk("R11 none", {30'd0, irq_o}, 0);
      bus_write(8'h18, 32'h200);
      rd_chk("R10 status lo", 8'h24, 32'h200);
      chk("R11 low line", {30'd0, irq_o}, 32'h1);
      bus_write(8'h18, 32'h0010_0000);
      rd_chk("R10 status both", 8'h24, 32'h0010_0200);
      chk("R11 both lines", {30'd0, irq_o}, 32'h3);
      bus_write(8'h1C, 32'h200);
      chk("R11 high line", {30'd0, irq_o}, 32'h2);
      bus_write(8'h28, 32'h0010_0000);
      chk("R11 cleared", {30'd0, irq_o}, 0);
      rd_chk("R10 raw left", 8'h20, 32'h200);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_mask;
      t_edge;
      t_level;
      t_invalid;
      t_detect;
      t_race;
      t_clear;
      t_status_irq;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule